// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register-mapped mailbox through which a host CPU hands commands to a display microcontroller. The host sees three registers on a simple synchronous register bus. The first is a command word: an opcode byte and two argument bytes. The second is a full-width parameter word, such as a ramp boundary or a frame-ramp count. The third is a control word that holds a doorbell bit and a sticky overrun bit.

To post a command, the host fills the parameter and command words and then rings the doorbell. The controller side receives a one-cycle command-valid strobe. Along with it come the captured opcode, both argument bytes, the parameter word, and a one-hot decode of which opcode arrived. The doorbell stays set until the controller acknowledges. The host therefore polls the doorbell until it reads 0, under its own timeout, before it posts again.

The argument bytes have different meanings for different opcodes. The pipe-select opcode uses argument byte 1 as the pipe number. The dimming-level opcode uses argument byte 2 as the level, and a level of 255 means dimming is switched off at once. The backlight opcode carries its value in the parameter word.

Top module: `mbx_host_mcu`

## Requirements
- R1: After a synchronous reset, the following are all 0: the doorbell, the overrun flag, the command and parameter words, and every controller-side output.
- R2: While the doorbell is 0, a host write to the command word (address 0) or the parameter word (address 1) reads back on the next read. Read data appears on the cycle after the read strobe. Bits 31:24 of the command word always read 0: byte 0 is the opcode, byte 1 is argument 1 and byte 2 is argument 2.
- R3: A host write to the control word (address 2) with bit 0 set, while the doorbell is 0, sets the doorbell. It also raises mc_cmd_valid for exactly one cycle, the cycle after the write. In that cycle the controller outputs carry the opcode, both arguments and the parameter word that were held at the time of the write.
- R4: While the doorbell is 1, host writes to the command and parameter words are ignored. Both the readback and the controller-side outputs stay unchanged.
- R5: A host write of 1 to control bit 0 while the doorbell is already 1 is ignored and produces no strobe. It sets the sticky overrun flag, which reads as control bit 1.
- R6: A host write of 0 to control bit 0 has no effect on the doorbell.
- R7: mc_ack while the doorbell is 1 clears the doorbell on the next cycle. mc_ack while the doorbell is 0 has no effect.
- R8: A host write to the control word with bit 1 set clears the overrun flag. A new overrun in the same cycle takes priority over the clear.
- R9: The captured opcode is decoded one-hot: 0x65 raises mc_is_level, 0x66 raises mc_is_pipe, and 0x67 raises mc_is_blite; any other opcode raises none of them. mc_dim_off is 1 only for opcode 0x65 with argument 2 equal to 0xFF.
- R10: mc_pending always equals the doorbell bit that the host reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select: 0 command, 1 parameter, 2 control |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data, valid one cycle after host_rd |
| mc_ack | input | 1 | Controller acknowledge, clears the doorbell |
| mc_cmd_valid | output | 1 | One-cycle strobe on a new command |
| mc_pending | output | 1 | Doorbell level |
| mc_opcode | output | 8 | Captured opcode |
| mc_arg1 | output | 8 | Captured argument byte 1 (pipe number) |
| mc_arg2 | output | 8 | Captured argument byte 2 (level) |
| mc_data | output | DATA_W | Captured parameter word |
| mc_is_level | output | 1 | Opcode is dimming-level set |
| mc_is_pipe | output | 1 | Opcode is pipe select |
| mc_is_blite | output | 1 | Opcode is backlight set |
| mc_dim_off | output | 1 | Dimming-level set with the immediate-off level |

## Verification
The assertions assume the controller drives mc_ack only as a single-cycle response. They also assume host_wr and host_rd are never asserted in the same cycle. The stimulus follows both rules by driving every bus access and every acknowledge from tasks that hold a strobe for exactly one clock. The random passes mix valid opcodes with arbitrary ones and sometimes ring the doorbell twice before acknowledging, so both the overrun path and the frozen-capture path are exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 2;
  localparam int BYTE_W = 8;
  localparam int CMD_BYTES = 3;
  localparam int CMD_W = BYTE_W * CMD_BYTES;

  localparam logic [ADDR_W-1:0] RA_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] RA_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] RA_CTRL = 2'd2;

  localparam int CTRL_BELL_BIT = 0;
  localparam int CTRL_OVR_BIT  = 1;

  localparam logic [BYTE_W-1:0] OPC_LEVEL = 8'h65;
  localparam logic [BYTE_W-1:0] OPC_PIPE  = 8'h66;
  localparam logic [BYTE_W-1:0] OPC_BLITE = 8'h67;
  localparam logic [BYTE_W-1:0] LEVEL_OFF = 8'hFF;

  typedef struct packed {
    logic [BYTE_W-1:0] arg2;
    logic [BYTE_W-1:0] arg1;
    logic [BYTE_W-1:0] opcode;
  } mbx_cmd_t;
endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 frozen,
  output mbx_cmd_t             cmd_q,
  output logic [DATA_W-1:0]    data_q
);
  logic [CMD_BYTES-1:0][BYTE_W-1:0] lanes;
  logic cmd_we;
  logic data_we;

  assign cmd_we  = wr && !frozen && (addr == RA_CMD);
  assign data_we = wr && !frozen && (addr == RA_DATA);

  for (genvar b = 0; b < CMD_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lanes[b] <= '0;
      end else if (cmd_we) begin
        lanes[b] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (data_we) begin
      data_q <= wdata;
    end
  end

  assign cmd_q = mbx_cmd_t'(lanes);
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic ring_req,
  input  logic ovr_clr,
  input  logic ack,
  output logic launch,
  output logic bell_q,
  output logic fire_q,
  output logic ovr_q
);
  logic ovr_set;

  assign launch  = ring_req && !bell_q;
  assign ovr_set = ring_req && bell_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bell_q <= 1'b0;
      fire_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      fire_q <= launch;
      if (launch) begin
        bell_q <= 1'b1;
      end else if (ack) begin
        bell_q <= 1'b0;
      end
      if (ovr_set) begin
        ovr_q <= 1'b1;
      end else if (ovr_clr) begin
        ovr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_capture.sv
module mbx_capture
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  mbx_cmd_t           cmd_in,
  input  logic [DATA_W-1:0]  data_in,
  output mbx_cmd_t           cmd_out,
  output logic [DATA_W-1:0]  data_out,
  output logic               is_level,
  output logic               is_pipe,
  output logic               is_blite,
  output logic               dim_off
);
  logic d_level;
  logic d_pipe;
  logic d_blite;
  logic d_off;

  always_comb begin
    d_level = (cmd_in.opcode == OPC_LEVEL);
    d_pipe  = (cmd_in.opcode == OPC_PIPE);
    d_blite = (cmd_in.opcode == OPC_BLITE);
    d_off   = d_level && (cmd_in.arg2 == LEVEL_OFF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_out  <= '0;
      data_out <= '0;
      is_level <= 1'b0;
      is_pipe  <= 1'b0;
      is_blite <= 1'b0;
      dim_off  <= 1'b0;
    end else if (launch) begin
      cmd_out  <= cmd_in;
      data_out <= data_in;
      is_level <= d_level;
      is_pipe  <= d_pipe;
      is_blite <= d_blite;
      dim_off  <= d_off;
    end
  end
endmodule

// File: rtl/mbx_host_mcu.sv
module mbx_host_mcu
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [1:0]         host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               mc_ack,
  output logic               mc_cmd_valid,
  output logic               mc_pending,
  output logic [7:0]         mc_opcode,
  output logic [7:0]         mc_arg1,
  output logic [7:0]         mc_arg2,
  output logic [DATA_W-1:0]  mc_data,
  output logic               mc_is_level,
  output logic               mc_is_pipe,
  output logic               mc_is_blite,
  output logic               mc_dim_off
);
  localparam int PAD_W = DATA_W - CMD_W;

  mbx_cmd_t          cmd_sh;
  logic [DATA_W-1:0] data_sh;
  mbx_cmd_t          cmd_cap;
  logic              bell;
  logic              ovr;
  logic              launch;
  logic              ctrl_wr;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr = host_wr && (host_addr == RA_CTRL);

  mbx_host_regs #(.DATA_W(DATA_W)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr     (host_wr),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .frozen (bell),
    .cmd_q  (cmd_sh),
    .data_q (data_sh)
  );

  mbx_doorbell bell_i (
    .clk      (clk),
    .rst      (rst),
    .ring_req (ctrl_wr && host_wdata[CTRL_BELL_BIT]),
    .ovr_clr  (ctrl_wr && host_wdata[CTRL_OVR_BIT]),
    .ack      (mc_ack),
    .launch   (launch),
    .bell_q   (bell),
    .fire_q   (mc_cmd_valid),
    .ovr_q    (ovr)
  );

  mbx_capture #(.DATA_W(DATA_W)) cap_i (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .cmd_in   (cmd_sh),
    .data_in  (data_sh),
    .cmd_out  (cmd_cap),
    .data_out (mc_data),
    .is_level (mc_is_level),
    .is_pipe  (mc_is_pipe),
    .is_blite (mc_is_blite),
    .dim_off  (mc_dim_off)
  );

  always_comb begin
    rd_mux = '0;
    case (host_addr)
      RA_CMD:  rd_mux = {{PAD_W{1'b0}}, cmd_sh};
      RA_DATA: rd_mux = data_sh;
      RA_CTRL: begin
        rd_mux[CTRL_BELL_BIT] = bell;
        rd_mux[CTRL_OVR_BIT]  = ovr;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      host_rdata <= rd_mux;
    end
  end

  assign mc_pending = bell;
  assign mc_opcode  = cmd_cap.opcode;
  assign mc_arg1    = cmd_cap.arg1;
  assign mc_arg2    = cmd_cap.arg2;
endmodule

// File: rtl/mbx_host_mcu_chk.sv
module mbx_host_mcu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic [1:0]        host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              mc_ack,
  input logic              mc_cmd_valid,
  input logic              mc_pending,
  input logic [7:0]        mc_opcode,
  input logic [DATA_W-1:0] mc_data,
  input logic              mc_is_level,
  input logic              mc_is_pipe,
  input logic              mc_is_blite
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mc_cmd_valid |=> !mc_cmd_valid); // R3
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    mc_cmd_valid |-> $rose(mc_pending)); // R3
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mc_pending && !mc_cmd_valid) |-> ($stable(mc_opcode) && $stable(mc_data))); // R4
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd2 && host_wdata[0] && mc_pending) |=> !mc_cmd_valid); // R5
  AST_BELL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mc_pending && !mc_ack) |=> mc_pending); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (mc_pending && mc_ack) |=> !mc_pending); // R7
  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mc_is_level, mc_is_pipe, mc_is_blite})); // R9
endmodule

bind mbx_host_mcu mbx_host_mcu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .host_wr      (host_wr),
  .host_addr    (host_addr),
  .host_wdata   (host_wdata),
  .mc_ack       (mc_ack),
  .mc_cmd_valid (mc_cmd_valid),
  .mc_pending   (mc_pending),
  .mc_opcode    (mc_opcode),
  .mc_data      (mc_data),
  .mc_is_level  (mc_is_level),
  .mc_is_pipe   (mc_is_pipe),
  .mc_is_blite  (mc_is_blite)
);

// File: tb/mbx_host_mcu_tb_top.sv
module mbx_host_mcu_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr, host_rd, mc_ack;
  logic [1:0]  host_addr;
  logic [31:0] host_wdata, host_rdata, mc_data;
  logic        mc_cmd_valid, mc_pending, mc_is_level, mc_is_pipe, mc_is_blite, mc_dim_off;
  logic [7:0]  mc_opcode, mc_arg1, mc_arg2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic pulse_seen;
  logic [31:0] rv;

  always #2 clk = ~clk;

  mbx_host_mcu #(.DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mc_ack(mc_ack), .mc_cmd_valid(mc_cmd_valid), .mc_pending(mc_pending),
    .mc_opcode(mc_opcode), .mc_arg1(mc_arg1), .mc_arg2(mc_arg2), .mc_data(mc_data),
    .mc_is_level(mc_is_level), .mc_is_pipe(mc_is_pipe), .mc_is_blite(mc_is_blite),
    .mc_dim_off(mc_dim_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dec(input logic [7:0] op, input logic [7:0] a2);
    exp_dec = {op == 8'h65, op == 8'h66, op == 8'h67, (op == 8'h65) && (a2 == 8'hFF)};
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    pulse_seen = mc_cmd_valid;
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic do_ack();
    mc_ack = 1'b1;
    @(negedge clk);
    mc_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; host_wr = 1'b0; host_rd = 1'b0; mc_ack = 1'b0;
    host_addr = '0; host_wdata = '0; pulse_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pending", {31'b0, mc_pending}, 32'd0);
    chk("R1 valid", {31'b0, mc_cmd_valid}, 32'd0);
    chk("R1 opcode", {24'b0, mc_opcode}, 32'd0);
    bus_rd(2'd2, rv); chk("R1 ctrl", rv, 32'd0);
    bus_rd(2'd0, rv); chk("R1 cmd", rv, 32'd0);

    bus_wr(2'd0, 32'hAB_FF_11_65);
    bus_wr(2'd1, 32'h0000_FFFF);
    bus_rd(2'd0, rv); chk("R2 cmd readback", rv, 32'h00_FF_11_65);
    bus_rd(2'd1, rv); chk("R2 data readback", rv, 32'h0000_FFFF);

    bus_wr(2'd2, 32'd1);
    chk("R3 pulse", {31'b0, pulse_seen}, 32'd1);
    chk("R3 opcode", {24'b0, mc_opcode}, 32'h65);
    chk("R3 arg1", {24'b0, mc_arg1}, 32'h11);
    chk("R3 arg2", {24'b0, mc_arg2}, 32'hFF);
    chk("R3 data", mc_data, 32'h0000_FFFF);
    chk("R9 dec level off", {28'b0, mc_is_level, mc_is_pipe, mc_is_blite, mc_dim_off}, 32'b1001);
    @(negedge clk);
    chk("R3 pulse ends", {31'b0, mc_cmd_valid}, 32'd0);
    chk("R10 pending", {31'b0, mc_pending}, 32'd1);
    bus_rd(2'd2, rv); chk("R10 ctrl bell", rv, 32'd1);

    bus_wr(2'd0, 32'h00_00_07_67);
    bus_wr(2'd1, 32'h1234_5678);
    bus_rd(2'd0, rv); chk("R4 cmd frozen", rv, 32'h00_FF_11_65);
    bus_rd(2'd1, rv); chk("R4 data frozen", rv, 32'h0000_FFFF);
    chk("R4 mc opcode", {24'b0, mc_opcode}, 32'h65);

    bus_wr(2'd2, 32'd0);
    bus_rd(2'd2, rv); chk("R6 write zero", rv, 32'd1);

    bus_wr(2'd2, 32'd1);
    chk("R5 no pulse", {31'b0, pulse_seen}, 32'd0);
    bus_rd(2'd2, rv); chk("R5 overrun", rv, 32'd3);

    do_ack();
    chk("R7 cleared", {31'b0, mc_pending}, 32'd0);
    bus_rd(2'd2, rv); chk("R7 ctrl", rv, 32'd2);
    do_ack();
    chk("R7 idle ack", {31'b0, mc_cmd_valid | mc_pending}, 32'd0);
    bus_rd(2'd2, rv); chk("R8 still set", rv, 32'd2);
    bus_wr(2'd2, 32'd2);
    bus_rd(2'd2, rv); chk("R8 cleared", rv, 32'd0);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] op, a1, a2;
      logic [31:0] d;
      case ($urandom % 5)
        0: op = 8'h65;
        1: op = 8'h66;
        2: op = 8'h67;
        default: op = 8'($urandom);
      endcase
      a1 = 8'($urandom);
      a2 = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      d = $urandom;
      bus_wr(2'd1, d);
      bus_wr(2'd0, {8'($urandom), a2, a1, op});
      bus_wr(2'd2, 32'd1);
      chk("R3 rnd pulse", {31'b0, pulse_seen}, 32'd1);
      chk("R3 rnd cmd", {8'b0, mc_arg2, mc_arg1, mc_opcode}, {8'b0, a2, a1, op});
      chk("R3 rnd data", mc_data, d);
      chk("R9 rnd decode", {28'b0, mc_is_level, mc_is_pipe, mc_is_blite, mc_dim_off},
          {28'b0, exp_dec(op, a2)});
      if ($urandom % 2 == 1) begin
        bus_wr(2'd0, $urandom);
        bus_wr(2'd2, 32'd1);
        chk("R5 rnd no pulse", {31'b0, pulse_seen}, 32'd0);
        chk("R4 rnd frozen", {24'b0, mc_opcode}, {24'b0, op});
        bus_rd(2'd2, rv); chk("R5 rnd overrun", rv, 32'd3);
        bus_wr(2'd2, 32'd2);
        bus_rd(2'd2, rv); chk("R8 rnd clear", rv, 32'd1);
      end
      do_ack();
      chk("R7 rnd ack", {31'b0, mc_pending}, 32'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule